// File: doc/BRIEF.md
# Two-Bank Interrupt Line Collector

This block gathers up to 64 interrupt request lines into a single interrupt output for a processor. The lines are split into two banks of 32. Each bank has four word registers on a small read/write register bus: a latched event word, an enable word, a write-one-to-clear acknowledge word and a live line-state word. Lines are synchronised with two flops before any use.

Most lines are edge-type. An edge-type line records a rising edge in its event bit, but only while the line is enabled. The bit then stays set until software acknowledges it. A fixed per-bank mask marks some lines as level-type. Those lines are never latched. They drive the interrupt output directly, for as long as they are high and enabled. The output is high whenever an enabled line has either a latched event or an active level.

Software enables the lines it cares about and takes the interrupt. It reads the event and line-state words to find the cause, then writes the acknowledge word. Turning on an enable bit while an edge-type line is already high does not create an event. Only the next rising edge does.

Top module: `legacy_irq_ctrl`

## Requirements
- R1: After reset all enable bits and event bits are 0, `irq_out` is low and `bus_rdata` is 0. `irq_out` stays low until a nonzero value is written to an enable word.
- R2: Byte addresses are decoded from `bus_addr`. Lines 0–31 occupy 0x20–0x2C and lines 32–63 occupy 0x10–0x1C. Within a bank the word order is event (+0x0), enable (+0x4), acknowledge (+0x8), line state (+0xC). Bit n of a bank word belongs to line (bank base line + n). Read data appears on `bus_rdata` after the clock edge that samples `bus_rd`, and holds until the next read.
- R3: The enable word reads back the last value written to it.
- R4: A rising edge on an enabled edge-type line sets its event bit and raises `irq_out`. The bit stays set after the line falls.
- R5: Writing 1 to an acknowledge bit clears the matching event bit. Writing 0 leaves it unchanged. The acknowledge word reads as 0.
- R6: A rising edge on a line whose enable bit is 0 does not set its event bit.
- R7: Setting an enable bit while that edge-type line is already high sets no event bit and leaves `irq_out` low. A later rising edge does set the event bit.
- R8: Lines 20–28 of the low bank are level-type (mask 0x1FF00000). The high bank has none. A level-type line never sets an event bit. While it is enabled, `irq_out` follows its synchronised state.
- R9: The line-state word returns the synchronised state of all 32 lines of its bank, whatever their type and enable.
- R10: `irq_out` is the OR over both banks of ((event | (line state & level mask)) & enable). Clearing an enable bit hides a pending event without clearing it.
- R11: These accesses are unmapped: offsets 0x00–0x0F and 0x30–0x3F, and any address with nonzero low two bits. Unmapped accesses read 0 and ignore writes. Writes to the event and line-state words have no effect.
- R12: When an acknowledge of an event bit happens in the same cycle as a new rising edge on that line, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 64 | Raw interrupt request lines |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte address inside the 64-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
An event bit stuck low loses an interrupt: `irq_out` fails to rise two cycles after the synchronised edge, and the event word reads 0 in the cycle after the read. An event bit stuck high shows up right after its acknowledge, as a nonzero event word and an `irq_out` that stays high. A bad enable bit shows up in the enable readback or as `irq_out` ignoring its mask. A mistaken edge detector shows up as an event created when an already-high line is enabled, or as a level line appearing in the event word.

// File: rtl/bic_pkg.sv
package bic_pkg;
    // Word select within a bank, taken from address bits [3:2]
    typedef enum logic [1:0] {
        REG_EVENT  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ACK    = 2'd2,
        REG_LEVEL  = 2'd3
    } reg_sel_e;

    localparam int NUM_BANKS = 2;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] live,
    output logic [W-1:0] rise
);
    logic [W-1:0] meta_q, stab_q, prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    assign live = stab_q;
    assign rise = stab_q & ~prev_q;
endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import bic_pkg::*;
#(
    parameter int           W          = 32,
    parameter logic [W-1:0] LEVEL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines,
    input  logic         hit,
    input  logic         wr,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rd_word,
    output logic         pending
);
    logic [W-1:0] live, rise;
    logic [W-1:0] event_q, enable_q;
    logic [W-1:0] ack_clr, edge_set;

    line_sync #(.W(W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (lines),
        .live (live),
        .rise (rise)
    );

    always_comb begin
        ack_clr  = (hit && wr && sel == REG_ACK) ? wdata : '0;
        edge_set = rise & enable_q & ~LEVEL_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            event_q  <= '0;
            enable_q <= '0;
        end else begin
            // a fresh edge wins over a simultaneous acknowledge
            event_q <= (event_q & ~ack_clr) | edge_set;
            if (hit && wr && sel == REG_ENABLE)
                enable_q <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            REG_EVENT:  rd_word = event_q;
            REG_ENABLE: rd_word = enable_q;
            REG_ACK:    rd_word = '0;
            REG_LEVEL:  rd_word = live;
            default:    rd_word = '0;
        endcase
    end

    assign pending = |((event_q | (live & LEVEL_MASK)) & enable_q);
endmodule

// File: rtl/legacy_irq_ctrl.sv
module legacy_irq_ctrl
    import bic_pkg::*;
#(
    parameter int                BANK_W          = 32,
    parameter int                ADDR_W          = 6,
    parameter logic [BANK_W-1:0] LOW_LEVEL_MASK  = 32'h1FF0_0000,
    parameter logic [BANK_W-1:0] HIGH_LEVEL_MASK = 32'h0000_0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] irq_lines,
    input  logic                        bus_rd,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [BANK_W-1:0]           bus_wdata,
    output logic [BANK_W-1:0]           bus_rdata,
    output logic                        irq_out
);
    localparam int LINES = NUM_BANKS * BANK_W;

    reg_sel_e                   sel;
    logic                       aligned;
    logic [NUM_BANKS-1:0]       hit, pend;
    logic [BANK_W-1:0]          word [NUM_BANKS];
    logic [BANK_W-1:0]          rd_mux;

    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // low lines at 0x20, high lines at 0x10
        localparam logic [1:0]        BASE = (b == 0) ? 2'b10 : 2'b01;
        localparam logic [BANK_W-1:0] MASK = (b == 0) ? LOW_LEVEL_MASK : HIGH_LEVEL_MASK;

        assign hit[b] = aligned && (bus_addr[ADDR_W-1:4] == BASE);

        irq_bank #(.W(BANK_W), .LEVEL_MASK(MASK)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .lines  (irq_lines[b*BANK_W +: BANK_W]),
            .hit    (hit[b]),
            .wr     (bus_wr),
            .sel    (sel),
            .wdata  (bus_wdata),
            .rd_word(word[b]),
            .pending(pend[b])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (hit[b]) rd_mux = rd_mux | word[b];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    assign irq_out = |pend;

    logic unused_ok;
    assign unused_ok = (LINES == 0);
endmodule

// File: rtl/bic_checker.sv
module bic_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] irq_lines,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [5:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        irq_out
);
    logic [2:0] age;
    logic       en_written;
    logic       unmapped;

    assign unmapped = (bus_addr[5:4] == 2'b00) || (bus_addr[5:4] == 2'b11) || (bus_addr[1:0] != 2'b00);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age        <= '0;
            en_written <= 1'b0;
        end else begin
            if (age != 3'd7) age <= age + 3'd1;
            if (bus_wr && !unmapped && bus_addr[3:2] == 2'b01 && bus_wdata != 32'h0)
                en_written <= 1'b1;
        end
    end

    assert_unmapped_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |=> (bus_rdata == 32'h0));

    assert_ack_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !unmapped && bus_addr[3:2] == 2'b10) |=> (bus_rdata == 32'h0));

    assert_quiet_until_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_written |-> !irq_out);

    assert_level_reg_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd3 && bus_rd && bus_addr == 6'h2C) |=> (bus_rdata == $past(irq_lines[31:0], 3)));
endmodule

bind legacy_irq_ctrl bic_checker u_bic_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_lines(irq_lines),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_out  (irq_out)
);

// File: tb/legacy_irq_ctrl_bench.sv
module legacy_irq_ctrl_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_lines = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    logic  rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    legacy_irq_ctrl u_legacy_irq_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_lines(irq_lines),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_out  (irq_out)
    );

    // monitor: compare read results against the scoreboard queue
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                errors++;
                $display("FAIL %s: rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_word(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_word(input logic [5:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        checks++;
        if (irq_out !== exp) begin
            errors++;
            $display("FAIL %s: irq_out=%b expected=%b", tag, irq_out, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd_word(6'h24, 32'h0, "R1 low enable reset");
        rd_word(6'h14, 32'h0, "R1 high enable reset");
        rd_word(6'h20, 32'h0, "R1 low event reset");
        // R3 enable readback, R2 word placement
        wr_word(6'h24, 32'h0000_0021);
        wr_word(6'h14, 32'h8000_0001);
        rd_word(6'h24, 32'h0000_0021, "R3 low enable readback");
        rd_word(6'h14, 32'h8000_0001, "R3 high enable readback");
        // R4 edge latch
        irq_lines[5] = 1'b1; idle(4);
        rd_word(6'h20, 32'h0000_0020, "R4 event set on edge");
        chk_irq(1'b1, "R4 irq raised");
        irq_lines[5] = 1'b0; idle(4);
        rd_word(6'h20, 32'h0000_0020, "R4 event held after fall");
        // R5 acknowledge
        wr_word(6'h28, 32'h0000_0001);
        rd_word(6'h20, 32'h0000_0020, "R5 zero ack bit no effect");
        chk_irq(1'b1, "R5 irq kept");
        wr_word(6'h28, 32'h0000_0020);
        rd_word(6'h20, 32'h0, "R5 ack clears");
        chk_irq(1'b0, "R5 irq dropped");
        rd_word(6'h28, 32'h0, "R5 ack reads zero");
        // R2 high bank at 0x10
        irq_lines[32] = 1'b1; idle(4);
        rd_word(6'h10, 32'h0000_0001, "R2 high bank event");
        rd_word(6'h20, 32'h0, "R2 low bank untouched");
        chk_irq(1'b1, "R2 irq from high bank");
        wr_word(6'h18, 32'h0000_0001);
        irq_lines[32] = 1'b0; idle(4);
        rd_word(6'h10, 32'h0, "R2 high bank acked");
        chk_irq(1'b0, "R2 irq idle");
        // R6 disabled line
        irq_lines[1] = 1'b1; idle(4);
        rd_word(6'h20, 32'h0, "R6 disabled edge ignored");
        chk_irq(1'b0, "R6 irq low");
        // R7 enable while already high
        wr_word(6'h24, 32'h0000_0023); idle(4);
        rd_word(6'h20, 32'h0, "R7 no event on enable");
        chk_irq(1'b0, "R7 irq low on enable");
        irq_lines[1] = 1'b0; idle(4);
        irq_lines[1] = 1'b1; idle(4);
        rd_word(6'h20, 32'h0000_0002, "R7 later edge latches");
        chk_irq(1'b1, "R7 irq on later edge");
        wr_word(6'h28, 32'h0000_0002);
        irq_lines[1] = 1'b0; idle(4);
        chk_irq(1'b0, "R7 irq cleared");
        // R8 level line 22
        wr_word(6'h24, 32'h0040_0023);
        irq_lines[22] = 1'b1; idle(4);
        chk_irq(1'b1, "R8 level irq live");
        rd_word(6'h20, 32'h0, "R8 level not latched");
        irq_lines[22] = 1'b0; idle(4);
        chk_irq(1'b0, "R8 level irq follows input");
        // R9 line state words
        irq_lines = 64'h1234_5678_A5A5_0F0F; idle(4);
        rd_word(6'h2C, 32'hA5A5_0F0F, "R9 low line state");
        rd_word(6'h1C, 32'h1234_5678, "R9 high line state");
        irq_lines = '0; idle(4);
        wr_word(6'h28, 32'hFFFF_FFFF);
        wr_word(6'h18, 32'hFFFF_FFFF);
        rd_word(6'h20, 32'h0, "R9 cleanup low");
        chk_irq(1'b0, "R9 cleanup irq");
        // R10 enable masks a pending event
        irq_lines[0] = 1'b1; idle(4);
        chk_irq(1'b1, "R10 irq with event");
        wr_word(6'h24, 32'h0040_0022);
        chk_irq(1'b0, "R10 masked event hidden");
        rd_word(6'h20, 32'h0000_0001, "R10 event retained");
        wr_word(6'h24, 32'h0040_0023);
        chk_irq(1'b1, "R10 irq back on unmask");
        irq_lines[0] = 1'b0;
        wr_word(6'h28, 32'h0000_0001); idle(3);
        chk_irq(1'b0, "R10 irq idle");
        // R11 unmapped and read-only words
        wr_word(6'h00, 32'hFFFF_FFFF);
        wr_word(6'h34, 32'hFFFF_FFFF);
        wr_word(6'h25, 32'h0000_0000);
        wr_word(6'h20, 32'hFFFF_FFFF);
        wr_word(6'h2C, 32'hFFFF_FFFF);
        rd_word(6'h00, 32'h0, "R11 unmapped low read");
        rd_word(6'h34, 32'h0, "R11 unmapped high read");
        rd_word(6'h25, 32'h0, "R11 misaligned read");
        rd_word(6'h24, 32'h0040_0023, "R11 enable unchanged");
        rd_word(6'h20, 32'h0, "R11 event write ignored");
        chk_irq(1'b0, "R11 irq low");
        // R12 ack colliding with a new edge
        irq_lines[5] = 1'b1; idle(4);
        irq_lines[5] = 1'b0; idle(4);
        irq_lines[5] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr_word(6'h28, 32'h0000_0020);
        rd_word(6'h20, 32'h0000_0020, "R12 edge beats ack");
        chk_irq(1'b1, "R12 irq stays");
        wr_word(6'h28, 32'h0000_0020);
        rd_word(6'h20, 32'h0, "R12 later ack clears");
        idle(3);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R2 scoreboard: pending=%0d expected=0", sb_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule